// File: doc/BRIEF.md
# Bitwise ternary logic unit

This unit applies one programmable three-input Boolean function to every bit position of three operand words at once. The function is an 8-bit truth table: for each bit position, the three operand bits at that position form a 3-bit index, and the truth-table bit at that index becomes the result bit. Any of the 256 possible three-input functions can be selected this way, including AND, OR, XOR, majority and bitwise select.

The truth table arrives as a plain 8-bit input. Extracting it from an instruction word is done elsewhere. Every bit position is always computed; there is no narrow mode. The result is registered, so it appears one clock after a valid input. It comes with a 2-bit carry field that is always zero, for datapaths that expect a carry from every functional unit.

Top module: `tlu_top`

## Requirements
- R1: While `rst` is high and on the first edge after it, `res_vld` is 0, `res` is all zeros and `carry` is 0.
- R2: For every bit i, the result bit equals `tt[idx]`. The index is idx = {`opc[i]`, `opa[i]`, `opb[i]`}, so `opb` is the least significant index bit, `opa` the middle bit and `opc` the most significant bit.
- R3: `res_vld` is high exactly in the cycle after a cycle with `in_vld` high. `res` then holds the result for the inputs sampled in that earlier cycle.
- R4: Each result bit depends only on operand bits at the same position. An operand bit at position k has no effect on any other result position.
- R5: A truth table of 0x00 gives an all-zero result for any operands.
- R6: A truth table of 0xFF gives an all-ones result for any operands.
- R7: `carry` is 0 in every cycle.
- R8: While `in_vld` is low, `res` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and truth table are valid this cycle |
| opa | input | 64 | First operand, middle index bit |
| opb | input | 64 | Second operand, least significant index bit |
| opc | input | 64 | Third operand, most significant index bit |
| tt | input | 8 | Truth table; bit n is the output for index n |
| res_vld | output | 1 | Result valid |
| res | output | 64 | Registered result |
| carry | output | 2 | Carry field, always zero |

## Verification
The only internal state is the result register and its valid flag. A fault in either is visible on the ports one clock after the input that caused it. A wrong index ordering or a swapped operand shows up as a mismatched bit on the first vector whose operand bits at some position differ. Random truth tables combined with random operands therefore expose it within a few vectors. A cross-wired bit lane appears in the single-bit-walk vectors, where the one set result bit lands at the wrong position. A register that loads while `in_vld` is low is caught in the idle-cycle hold checks.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned TT_W    = 1 << IDX_W;
  localparam int unsigned CARRY_W = 2;
endpackage

// File: rtl/tlu_bit_cell.sv
// One bit lane: the three operand bits select one truth-table entry.
module tlu_bit_cell #(
  parameter int unsigned IDX_W = tlu_pkg::IDX_W,
  localparam int unsigned TT_W = 1 << IDX_W
) (
  input  logic            a_bit,
  input  logic            b_bit,
  input  logic            c_bit,
  input  logic [TT_W-1:0] tt,
  output logic            y
);
  logic [IDX_W-1:0] sel;

  // b is the least significant index bit, a the middle, c the most significant
  always_comb begin
    sel = {c_bit, a_bit, b_bit};
    y   = tt[sel];
  end
endmodule

// File: rtl/tlu_array.sv
// Replicates the bit cell across the word; the lanes share only the truth table.
module tlu_array #(
  parameter int unsigned W    = tlu_pkg::DATA_W,
  parameter int unsigned TT_W = tlu_pkg::TT_W
) (
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [W-1:0]    opc,
  input  logic [TT_W-1:0] tt,
  output logic [W-1:0]    y
);
  localparam int unsigned IDX_W = $clog2(TT_W);

  for (genvar i = 0; i < W; i++) begin : g_lane
    tlu_bit_cell #(.IDX_W(IDX_W)) u_cell (
      .a_bit (opa[i]),
      .b_bit (opb[i]),
      .c_bit (opc[i]),
      .tt    (tt),
      .y     (y[i])
    );
  end
endmodule

// File: rtl/tlu_out_stage.sv
// Output register: loads on a valid input, otherwise holds its value.
module tlu_out_stage #(
  parameter int unsigned W = tlu_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic         q_vld,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q     <= '0;
    end else begin
      q_vld <= ld;
      if (ld) q <= d;
    end
  end
endmodule

// File: rtl/tlu_top.sv
module tlu_top #(
  parameter int unsigned W       = tlu_pkg::DATA_W,
  parameter int unsigned TT_W    = tlu_pkg::TT_W,
  parameter int unsigned CARRY_W = tlu_pkg::CARRY_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [W-1:0]       opa,
  input  logic [W-1:0]       opb,
  input  logic [W-1:0]       opc,
  input  logic [TT_W-1:0]    tt,
  output logic               res_vld,
  output logic [W-1:0]       res,
  output logic [CARRY_W-1:0] carry
);
  logic [W-1:0] comb_y;

  tlu_array #(.W(W), .TT_W(TT_W)) u_array (
    .opa (opa),
    .opb (opb),
    .opc (opc),
    .tt  (tt),
    .y   (comb_y)
  );

  tlu_out_stage #(.W(W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .ld    (in_vld),
    .d     (comb_y),
    .q_vld (res_vld),
    .q     (res)
  );

  // Logic operations never produce a carry.
  assign carry = '0;
endmodule

// File: rtl/tlu_chk.sv
module tlu_chk #(
  parameter int unsigned W       = tlu_pkg::DATA_W,
  parameter int unsigned TT_W    = tlu_pkg::TT_W,
  parameter int unsigned CARRY_W = tlu_pkg::CARRY_W
) (
  input logic               clk,
  input logic               rst,
  input logic               in_vld,
  input logic [W-1:0]       opa,
  input logic [W-1:0]       opb,
  input logic [W-1:0]       opc,
  input logic [TT_W-1:0]    tt,
  input logic               res_vld,
  input logic [W-1:0]       res,
  input logic [CARRY_W-1:0] carry
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!res_vld && res == '0));

  a_r2_lane0_lookup: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res[0] == $past(tt[{opc[0], opa[0], opb[0]}]));

  a_r2_top_lane_lookup: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res[W-1] == $past(tt[{opc[W-1], opa[W-1], opb[W-1]}]));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld);

  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !res_vld);

  a_r5_zero_table: assert property (@(posedge clk) disable iff (rst)
    (in_vld && tt == '0) |=> res == '0);

  a_r6_ones_table: assert property (@(posedge clk) disable iff (rst)
    (in_vld && tt == '1) |=> res == '1);

  a_r7_carry_zero: assert property (@(posedge clk) disable iff (rst)
    carry == '0);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(res));
endmodule

bind tlu_top tlu_chk #(.W(W), .TT_W(TT_W), .CARRY_W(CARRY_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .opa     (opa),
  .opb     (opb),
  .opc     (opc),
  .tt      (tt),
  .res_vld (res_vld),
  .res     (res),
  .carry   (carry)
);

// File: tb/sim_tlu_top.sv
module sim_tlu_top;
  localparam int W = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [W-1:0]  opa = '0, opb = '0, opc = '0;
  logic [7:0]    tt = '0;
  logic          res_vld;
  logic [W-1:0]  res;
  logic [1:0]    carry;

  int total = 0;
  int bad = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] last_exp = '0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  tlu_top u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb), .opc(opc),
    .tt(tt), .res_vld(res_vld), .res(res), .carry(carry)
  );

  // Reference model written from R2: index = {c, a, b}
  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, c,
                                         input logic [7:0] t);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = t[{c[i], a[i], b[i]}];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, b, c, input logic [7:0] t,
                       input string req);
    @(negedge clk);
    opa = a; opb = b; opc = c; tt = t; in_vld = 1'b1;
    exp_q.push_back(model(a, b, c, t));
    tag_q.push_back(req);
    last_exp = model(a, b, c, t);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_vld = 1'b0;
      opa = {$urandom, $urandom}; opb = {$urandom, $urandom};
      opc = {$urandom, $urandom}; tt = 8'($urandom);
    end
  endtask

  // Monitor: pop expected results as they appear
  always @(negedge clk) begin
    if (!rst) begin
      check("R7", {62'd0, carry}, '0);
      if (res_vld) begin
        if (exp_q.size() == 0) begin
          check("R3", {63'd0, res_vld}, '0);
        end else begin
          string t;
          logic [W-1:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, res, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {62'd0, res_vld, 1'b0} | {63'd0, carry != 0}, '0);
    check("R1", res, '0);
    @(negedge clk);
    rst = 1'b0;
    // R2: each index value selected individually, one-hot truth tables
    for (int n = 0; n < 8; n++)
      drive({W{1'b0}} | {W{n[1]}}, {W{n[0]}}, {W{n[2]}}, 8'(1 << n), "R2");
    // R2: fixed mixed pattern, majority and select
    drive(64'hF0F0_F0F0_F0F0_F0F0, 64'hCCCC_CCCC_CCCC_CCCC,
          64'hAAAA_AAAA_AAAA_AAAA, 8'hE8, "R2");
    drive(64'hF0F0_F0F0_F0F0_F0F0, 64'hCCCC_CCCC_CCCC_CCCC,
          64'hAAAA_AAAA_AAAA_AAAA, 8'hCA, "R2");
    // R4: single set bit in one operand lands only at its own position
    for (int k = 0; k < W; k += 7) begin
      drive(64'd1 << k, '0, '0, 8'b0000_0100, "R4");
      drive('0, 64'd1 << k, '0, 8'b0000_0010, "R4");
      drive('0, '0, 64'd1 << k, 8'b0001_0000, "R4");
    end
    // R5 and R6
    drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 8'h00, "R5");
    drive('1, '1, '1, 8'h00, "R5");
    drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 8'hFF, "R6");
    drive('0, '0, '0, 8'hFF, "R6");
    // R8: idle cycles with changing inputs, result must hold
    idle(1);
    @(negedge clk);
    check("R8", res, last_exp);
    idle(3);
    check("R8", res, last_exp);
    check("R3", {63'd0, res_vld}, '0);
    // R2/R3: random back-to-back and gapped traffic
    for (int n = 0; n < 300; n++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
            8'($urandom), "R3");
      if (n % 17 == 0) begin
        idle(2);
        check("R8", res, last_exp);
      end
    end
    idle(3);
    check("R3", 64'(exp_q.size()), '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule